// File: doc/BRIEF.md
# Maskable Interrupt and Periodic Rate Unit

This unit belongs to a real-time clock. It collects three interrupt sources into one active-low, open-drain request line: an alarm match, a periodic tick and an update-complete event. Each source has a latched flag and a separate enable bit. A flag is set whenever its event occurs, whether or not its enable is set. The request line is driven low only while at least one flag is set together with its enable. Software polls the sources by reading a status byte. That read clears every flag and releases the request line.

The unit also contains a prescaler that counts ticks of a 32.768 kHz time base. A 4-bit rate code selects one tap of this prescaler. The chosen tap drives both the periodic flag and a square-wave pin, and the square-wave pin is gated by its own enable. The rate code comes from a neighbouring register. The alarm-compare and update-complete pulses come from the timekeeping logic, which lies outside this unit.

Top module: `rtc_irq_unit`

## Requirements
- R1: Each of the three flags (periodic, alarm, update-complete) is set by its event whether or not its enable is set. A flag that has been set stays set until it is cleared.
- R2: The status byte reads bit 7 = request summary, bit 6 = periodic flag, bit 5 = alarm flag, bit 4 = update flag, and bits 3:0 = 0. The summary bit is the OR of each flag ANDed with its enable.
- R3: `irqN` is driven to 0 while the summary bit is 1. Otherwise it is high impedance.
- R4: A cycle with `statRd` high shows the current flags on `statData`. The flags are cleared at the clock edge that ends that cycle, which releases `irqN`. An event in the same cycle as the read leaves its flag set.
- R5: Rate codes map to the time between periodic events, counted in time-base ticks. Code 0 means no events. Code 1 gives 128 ticks and code 2 gives 256 ticks. Codes 3 to 15 give 2^(code-1) ticks, which is 4 ticks (8192 Hz) up to 16384 ticks (2 Hz).
- R6: With a nonzero code, the periodic flag is set once per selected period. With code 0 it is never set.
- R7: While the square-wave enable is 1 and the code is nonzero, `sqwOut` is a square wave with the selected period and a 50% duty cycle. Otherwise `sqwOut` is 0.
- R8: The prescaler advances only in cycles where `oscTick` is 1.
- R9: While `rstN` is low, all four enable bits and all flags are cleared, and the prescaler restarts from zero. `irqN` is then high impedance and `sqwOut` is 0.
- R10: When `enWe` is high, `enData` is written to the enables: bit 0 = periodic enable, bit 1 = alarm enable, bit 2 = update enable, bit 3 = square-wave enable. If a flag is already set when its enable is written to 1, `irqN` goes low at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset for enables, flags and prescaler |
| oscTick | input | 1 | One-cycle strobe per 32.768 kHz time-base tick |
| rateSel | input | 4 | Rate code selecting the prescaler tap |
| alarmEvt | input | 1 | Alarm-match event pulse |
| updateEvt | input | 1 | Update-complete event pulse |
| enWe | input | 1 | Write strobe for the enable bits |
| enData | input | 4 | Enable write data |
| statRd | input | 1 | Status read strobe; clears the flags |
| statData | output | 8 | Status byte |
| irqN | output | 1 | Open-drain interrupt request, driven low or high impedance |
| sqwOut | output | 1 | Gated square-wave output |

## Verification
The bench uses the default parameters: a 4-bit rate code and a 14-stage prescaler. With `oscTick` high in every cycle, even the 2 Hz tap completes a period in 16384 cycles. Every class of rate code can therefore be measured within one run: the two slow codes, the fastest code, a code in the middle and the slowest code. Halving the `oscTick` rate then shows that the prescaler follows the time base and not the system clock. Reads are placed in the same cycle as events, and enables are written after a flag has already latched, to probe the ordering cases.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic setPf;
    logic setAf;
    logic setUf;
    logic clrAll;
  } flagStrobe_t;

  // Enable bits in write order, bit 3 down to bit 0.
  typedef struct packed {
    logic sqwEn;
    logic uie;
    logic aie;
    logic pie;
  } enables_t;

  // Flag vector order used between modules: {periodic, alarm, update}.
  localparam int FLAG_PF = 2;
  localparam int FLAG_AF = 1;
  localparam int FLAG_UF = 0;

  // Prescaler bit that a rate code selects. Bit k has a period of
  // 2^(k+1) ticks. The two slow codes sit above the fast ladder.
  function automatic int tapIdx(input int code, input int slowCodes,
                                input int slowBase, input int fastOfs);
    if (code <= slowCodes) return code + slowBase;
    return code - fastOfs;
  endfunction

endpackage

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int FLAG_N = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enWe,
  input  logic [3:0]        enData,
  input  logic              alarmEvt,
  input  logic              updateEvt,
  input  logic              tickPulse,
  input  logic              statRd,
  input  logic [FLAG_N-1:0] flags,
  output enables_t          en,
  output flagStrobe_t       strb,
  output logic              irqReq
);

  logic [FLAG_N-1:0] enVec;

  // Enable register; every bit belongs to the reset-cleared subset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      en <= '0;
    end else if (enWe) begin
      en <= enables_t'(enData);
    end
  end

  // Event and read strobes go to the datapath unchanged, so the enables never gate a flag.
  always_comb begin
    strb.setPf  = tickPulse;
    strb.setAf  = alarmEvt;
    strb.setUf  = updateEvt;
    strb.clrAll = statRd;
  end

  always_comb begin
    enVec          = '0;
    enVec[FLAG_PF] = en.pie;
    enVec[FLAG_AF] = en.aie;
    enVec[FLAG_UF] = en.uie;
  end

  // Request summary over enabled flags only.
  assign irqReq = |(flags & enVec);

  // R9: enables are clear in the cycle after reset is seen low.
  a_r9_enables_reset: assert property (@(posedge clk) !rstN |=> (en == '0))
    else $error("enables not cleared by reset");

  // R10: a write takes effect at the next edge.
  a_r10_enable_write: assert property (@(posedge clk) disable iff (!rstN)
    enWe |=> (en == enables_t'($past(enData))))
    else $error("enable write lost");

endmodule

// File: rtl/rtc_irq_datapath.sv
module rtc_irq_datapath
  import rtc_irq_pkg::*;
#(
  parameter int RATE_W     = 4,
  parameter int SLOW_CODES = 2,
  parameter int SLOW_BASE  = 5,
  parameter int FAST_OFS   = 2,
  parameter int FLAG_N     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              oscTick,
  input  logic [RATE_W-1:0] rateSel,
  input  flagStrobe_t       strb,
  input  logic              sqwEn,
  input  logic              irqReq,
  output logic              tickPulse,
  output logic [FLAG_N-1:0] flags,
  output logic [7:0]        statData,
  output logic              irqN,
  output logic              sqwOut
);

  localparam int NCODES = 1 << RATE_W;
  localparam int DIV_W  = tapIdx(NCODES - 1, SLOW_CODES, SLOW_BASE, FAST_OFS) + 1;
  localparam int LOW_W  = 8 - 1 - FLAG_N;

  logic [DIV_W-1:0]  divCnt;
  logic [NCODES-1:0] tapVec;
  logic              tapSel;
  logic              tapPrev;
  logic [FLAG_N-1:0] setVec;

  // Prescaler: advances once per time-base tick.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (oscTick) begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  // One tap per rate code; code 0 is tied off.
  for (genvar c = 0; c < NCODES; c++) begin : g_tap
    if (c == 0) begin : g_off
      assign tapVec[c] = 1'b0;
    end else begin : g_on
      assign tapVec[c] = divCnt[tapIdx(c, SLOW_CODES, SLOW_BASE, FAST_OFS)];
    end
  end

  assign tapSel = tapVec[rateSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tapPrev <= 1'b0;
    end else begin
      tapPrev <= tapSel;
    end
  end

  // One pulse per rising edge of the selected tap.
  assign tickPulse = tapSel & ~tapPrev;

  always_comb begin
    setVec          = '0;
    setVec[FLAG_PF] = strb.setPf;
    setVec[FLAG_AF] = strb.setAf;
    setVec[FLAG_UF] = strb.setUf;
  end

  // Flags: a set beats a clear in the same cycle, so no event is lost.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags <= '0;
    end else begin
      for (int i = 0; i < FLAG_N; i++) begin
        if (setVec[i]) begin
          flags[i] <= 1'b1;
        end else if (strb.clrAll) begin
          flags[i] <= 1'b0;
        end
      end
    end
  end

  assign statData = {irqReq, flags, LOW_W'(0)};
  assign irqN     = irqReq ? 1'b0 : 1'bz;
  assign sqwOut   = sqwEn & tapSel;

  // R1: an alarm event leaves the alarm flag set.
  a_r1_alarm_latch: assert property (@(posedge clk) disable iff (!rstN)
    strb.setAf |=> flags[FLAG_AF])
    else $error("alarm flag not latched");

  // R1: an update event leaves the update flag set.
  a_r1_update_latch: assert property (@(posedge clk) disable iff (!rstN)
    strb.setUf |=> flags[FLAG_UF])
    else $error("update flag not latched");

  // R6: a tap edge leaves the periodic flag set.
  a_r6_periodic_latch: assert property (@(posedge clk) disable iff (!rstN)
    tickPulse |=> flags[FLAG_PF])
    else $error("periodic flag not latched");

  // R4: a read with no coincident event empties the flags.
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrAll && !strb.setPf && !strb.setAf && !strb.setUf) |=> (flags == '0))
    else $error("flags survive a read");

  // R8: the prescaler holds while no tick arrives.
  a_r8_div_hold: assert property (@(posedge clk) disable iff (!rstN)
    !oscTick |=> $stable(divCnt))
    else $error("prescaler moved without tick");

endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
  import rtc_irq_pkg::*;
#(
  parameter int RATE_W     = 4,
  parameter int SLOW_CODES = 2,
  parameter int SLOW_BASE  = 5,
  parameter int FAST_OFS   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              oscTick,
  input  logic [RATE_W-1:0] rateSel,
  input  logic              alarmEvt,
  input  logic              updateEvt,
  input  logic              enWe,
  input  logic [3:0]        enData,
  input  logic              statRd,
  output logic [7:0]        statData,
  output logic              irqN,
  output logic              sqwOut
);

  localparam int FLAG_N = 3;

  enables_t          en;
  flagStrobe_t       strb;
  logic              irqReq;
  logic              tickPulse;
  logic [FLAG_N-1:0] flags;

  rtc_irq_ctrl #(
    .FLAG_N(FLAG_N)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enWe     (enWe),
    .enData   (enData),
    .alarmEvt (alarmEvt),
    .updateEvt(updateEvt),
    .tickPulse(tickPulse),
    .statRd   (statRd),
    .flags    (flags),
    .en       (en),
    .strb     (strb),
    .irqReq   (irqReq)
  );

  rtc_irq_datapath #(
    .RATE_W    (RATE_W),
    .SLOW_CODES(SLOW_CODES),
    .SLOW_BASE (SLOW_BASE),
    .FAST_OFS  (FAST_OFS),
    .FLAG_N    (FLAG_N)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .oscTick  (oscTick),
    .rateSel  (rateSel),
    .strb     (strb),
    .sqwEn    (en.sqwEn),
    .irqReq   (irqReq),
    .tickPulse(tickPulse),
    .flags    (flags),
    .statData (statData),
    .irqN     (irqN),
    .sqwOut   (sqwOut)
  );

  // R7: with the gate off, the pin stays low.
  a_r7_sqw_gated: assert property (@(posedge clk) disable iff (!rstN)
    !en.sqwEn |-> !sqwOut)
    else $error("square wave leaks while disabled");

  // R3: the summary bit and the open-drain line agree.
  a_r3_irq_low: assert property (@(posedge clk) disable iff (!rstN)
    statData[7] |-> (irqN === 1'b0))
    else $error("request line not driven low");

  // R2: the low nibble of the status byte is always zero.
  a_r2_low_nibble: assert property (@(posedge clk) disable iff (!rstN)
    statData[3:0] == 4'h0)
    else $error("status low nibble nonzero");

endmodule

// File: tb/test_rtc_irq_unit.sv
module test_rtc_irq_unit;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       oscTick = 1'b1;
  logic [3:0] rateSel = 4'd0;
  logic       alarmEvt = 1'b0;
  logic       updateEvt = 1'b0;
  logic       enWe = 1'b0;
  logic [3:0] enData = 4'd0;
  logic       statRd = 1'b0;
  logic [7:0] statData;
  logic       irqN;
  logic       sqwOut;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit halfRate = 1'b0;
  bit done = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];

  always #10 clk = ~clk;

  rtc_irq_unit i_rtc_irq_unit (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .rateSel(rateSel),
    .alarmEvt(alarmEvt), .updateEvt(updateEvt), .enWe(enWe), .enData(enData),
    .statRd(statRd), .statData(statData), .irqN(irqN), .sqwOut(sqwOut)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Time-base strobe: every cycle, or every other cycle when halfRate is set.
  initial begin
    forever begin
      @(posedge clk);
      #1 oscTick = halfRate ? ~oscTick : 1'b1;
    end
  end

  // Monitor: compares each status read against the front of the queue.
  always @(negedge clk) begin
    if (statRd) begin
      if (expQ.size() == 0) begin
        errors++; checks++;
        $display("FAIL %s: unexpected read, actual %h expected none", "R4", statData);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (statData !== e) begin
          errors++;
          $display("FAIL %s: status actual %h expected %h", t, statData, e);
        end
      end
    end
  end

  function automatic int periodOf(input int code);
    if (code == 1) return 128;
    if (code == 2) return 256;
    return 1 << (code - 1);
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic readStat(input logic [7:0] e, input string tag);
    expQ.push_back(e);
    tagQ.push_back(tag);
    step(); statRd = 1'b1;
    step(); statRd = 1'b0;
  endtask

  task automatic writeEn(input logic [3:0] v);
    step(); enWe = 1'b1; enData = v;
    step(); enWe = 1'b0;
  endtask

  task automatic pulseAlarm();
    step(); alarmEvt = 1'b1;
    step(); alarmEvt = 1'b0;
  endtask

  task automatic pulseUpdate();
    step(); updateEvt = 1'b1;
    step(); updateEvt = 1'b0;
  endtask

  task automatic checkIrq(input bit expLow, input string tag);
    logic e;
    @(negedge clk);
    e = expLow ? 1'b0 : 1'bz;
    checks++;
    if (irqN !== e) begin
      errors++;
      $display("FAIL %s: irqN actual %b expected %b", tag, irqN, e);
    end
  endtask

  task automatic checkVal(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitPf(output int t, output bit ok);
    ok = 1'b0;
    t = 0;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (statData[6]) begin
        t = cyc;
        ok = 1'b1;
        return;
      end
    end
  endtask

  // R5/R6: skip the first edge after a code change, then time two flag edges.
  task automatic measure(input int code, input int expPeriod, input string tag);
    int ta, tb;
    bit ok;
    step(); rateSel = 4'(code);
    waitPf(ta, ok);
    readStat(8'h40, tag);
    waitPf(ta, ok);
    readStat(8'h40, tag);
    waitPf(tb, ok);
    readStat(8'h40, tag);
    checkVal(ok ? (tb - ta) : -1, expPeriod, tag);
  endtask

  task automatic sqwCount(input int n, output int rises, output int highs);
    logic prev;
    rises = 0; highs = 0;
    @(negedge clk); prev = sqwOut;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sqwOut && !prev) rises++;
      if (sqwOut) highs++;
      prev = sqwOut;
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    int r, h;
    repeat (3) step();
    rstN = 1'b1;
    step();

    // R9: state after reset.
    checkIrq(1'b0, "R9 reset irq");
    checkVal(int'(sqwOut), 0, "R9 reset sqw");
    readStat(8'h00, "R9 reset status");

    // R1/R2: alarm flag latches while masked; summary bit stays 0.
    pulseAlarm();
    checkIrq(1'b0, "R1 masked alarm irq");
    readStat(8'h20, "R1 masked alarm");
    readStat(8'h00, "R4 cleared after read");

    // R1: update flag latches while masked.
    pulseUpdate();
    readStat(8'h10, "R1 masked update");

    // R10/R3: enabling a flag that is already set raises the request.
    pulseAlarm();
    checkIrq(1'b0, "R3 before enable");
    writeEn(4'b0010);
    checkIrq(1'b1, "R10 late enable");
    readStat(8'hA0, "R2 alarm enabled");
    checkIrq(1'b0, "R4 released");

    // R2/R3: update enabled, alarm masked; both flags shown.
    writeEn(4'b0100);
    pulseAlarm();
    pulseUpdate();
    checkIrq(1'b1, "R3 update request");
    readStat(8'hB0, "R2 mixed flags");

    // R4: an event in the read cycle survives the clear.
    writeEn(4'b0000);
    step(); statRd = 1'b1; alarmEvt = 1'b1;
    expQ.push_back(8'h00); tagQ.push_back("R4 coincident read");
    step(); statRd = 1'b0; alarmEvt = 1'b0;
    readStat(8'h20, "R4 coincident event kept");

    // R6: code 0 never sets the periodic flag.
    repeat (600) step();
    readStat(8'h00, "R6 code zero idle");

    // R5/R6: period of several codes.
    measure(3, periodOf(3), "R5 code3");
    measure(1, periodOf(1), "R5 code1");
    measure(2, periodOf(2), "R5 code2");
    measure(6, periodOf(6), "R6 code6");
    measure(15, periodOf(15), "R5 code15");

    // R8: halving the time-base rate doubles the period.
    halfRate = 1'b1;
    measure(3, 2 * periodOf(3), "R8 half tick");
    halfRate = 1'b0;
    step();

    // R3: periodic flag with its enable drives the line.
    writeEn(4'b0001);
    begin
      int t; bit ok;
      waitPf(t, ok);
    end
    checkIrq(1'b1, "R3 periodic request");
    step(); rateSel = 4'd0;
    writeEn(4'b0000);
    readStat(8'h40, "R6 periodic flag");

    // R7: square wave gated off, then on with code 3, then code 0.
    step(); rateSel = 4'd3;
    sqwCount(64, r, h);
    checkVal(r + h, 0, "R7 sqw disabled");
    writeEn(4'b1000);
    sqwCount(64, r, h);
    checkVal(r, 16, "R7 sqw edges");
    checkVal(h, 32, "R7 sqw duty");
    step(); rateSel = 4'd0;
    sqwCount(64, r, h);
    checkVal(r + h, 0, "R7 sqw code zero");
    readStat(8'h40, "R6 flag from sqw run");

    // R9: reset clears enables and flags.
    writeEn(4'b1111);
    step(); rateSel = 4'd3;
    pulseAlarm();
    checkIrq(1'b1, "R9 before reset");
    step(); rateSel = 4'd0; rstN = 1'b0;
    repeat (2) step();
    rstN = 1'b1;
    checkIrq(1'b0, "R9 irq after reset");
    checkVal(int'(sqwOut), 0, "R9 sqw after reset");
    readStat(8'h00, "R9 flags after reset");
    pulseAlarm();
    checkIrq(1'b0, "R9 alarm enable cleared");
    readStat(8'h20, "R9 masked after reset");
    step(); rateSel = 4'd3;
    sqwCount(32, r, h);
    checkVal(r + h, 0, "R9 sqw enable cleared");

    repeat (4) step();
    done = 1'b1;
    finishRun();
  end

endmodule